// File: doc/BRIEF.md
# Background Tile Pixel Color Resolver

This block turns one screen coordinate into the six-bit system color that the tile background shows at that point. A request carries the pixel position (x from 0 to 255, y from 0 to 239), a two-bit choice of one of four 1 KiB tile maps and a one-bit choice of pattern bank. The block then reads five bytes in order from a shared video memory: the tile number from the selected map, the low and high bit-plane rows of that tile, the attribute byte that covers the pixel's 32x32 region, and finally the palette entry. The last byte read is reported as the color.

Memory accesses use a plain synchronous read port. The block presents an address with a one-cycle read enable, and the data appears on the read-data input one clock later. The block waits that cycle before it moves on, so a pixel takes ten clocks from acceptance to the result strobe. A request is taken only while the block is idle; a request presented while it is busy is dropped.

Top module: `bg_pixel_resolver`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, busy, mem_rd_en and out_valid are all low.
- R2: The first read after a request is accepted is at 0x2000 + map*0x400 + (y/8)*32 + (x/8). Here map is req_nt, and req_nt and req_bank are captured together with the coordinates.
- R3: The second and third reads fetch the tile's plane rows. The low row is at bank*0x1000 + tile*16 + (y mod 8), and the high row is 8 bytes above it. Here tile is the byte returned by the first read and bank is req_bank.
- R4: The fourth read fetches the attribute byte at 0x2000 + map*0x400 + 0x3C0 + (y/32)*8 + (x/32).
- R5: The two-bit color index has the high-plane bit as bit 1 and the low-plane bit as bit 0. Both bits are taken from bit position 7 - (x mod 8), so the leftmost pixel of a tile uses the MSB.
- R6: The sub-palette comes from the attribute byte according to the pixel's 16x16 quadrant inside its 32x32 region: bits [1:0] for upper-left, [3:2] for upper-right, [5:4] for lower-left and [7:6] for lower-right.
- R7: The fifth read is at 0x3F00 + sub-palette*4 + color index, and out_color equals bits [5:0] of the byte it returns.
- R8: When a request is accepted at a clock edge, mem_rd_en is high for exactly one cycle after edges 0, 2, 4, 6 and 8, counted from that edge. out_valid is high for exactly one cycle after edge 10, and busy is high from edge 0 until edge 10.
- R9: A request presented while busy is high is ignored: it starts no extra read and does not change the result of the pixel in progress. A request held high is accepted at the first edge after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pixel request strobe, taken when idle |
| req_x | input | 8 | Pixel column, 0 to 255 |
| req_y | input | 8 | Pixel row, 0 to 239 |
| req_nt | input | 2 | Tile map select |
| req_bank | input | 1 | Pattern bank select (0x0000 or 0x1000) |
| busy | output | 1 | A pixel is being resolved |
| mem_rd_en | output | 1 | Read strobe to video memory |
| mem_addr | output | 14 | Read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| out_valid | output | 1 | One-cycle result strobe |
| out_color | output | 6 | System color index |

## Verification
Two situations are hard to reach from the ports. The first is a new request that arrives in the cycle the result strobe fires, which is the only point where a request held high is accepted with no gap. The second is a set of pixels that lands on every attribute quadrant and every bit position within a tile. The bench holds req_valid high for long stretches and changes the coordinates every cycle, so the handover edge is hit many times and requests that arrive while busy are dropped. Directed coordinates on the 8, 16 and 32 pixel boundaries of all four maps and both banks cover the quadrants and bit positions. A hashed memory content makes every plane bit and sub-palette value occur.

// File: rtl/bg_resolve_pkg.sv
package bg_resolve_pkg;

  // fetch stages, in the order the resolver walks them
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NT,
    ST_LO,
    ST_HI,
    ST_AT,
    ST_PAL
  } stage_t;

  localparam int MAP_BASE    = 'h2000;
  localparam int MAP_STRIDE  = 10;     // log2 of the map size
  localparam int ATTR_OFFSET = 'h3C0;
  localparam int PAL_BASE    = 'h3F00;
  localparam int BANK_SHIFT  = 12;
  localparam int TILE_SHIFT  = 4;      // 16 bytes per tile
  localparam int PLANE_GAP   = 8;

endpackage

// File: rtl/bg_fetch_addr.sv
module bg_fetch_addr
  import bg_resolve_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int X_W    = 8,
  parameter int Y_W    = 8,
  parameter int TILE_W = 8
) (
  input  stage_t              stage,
  input  logic [X_W-4:0]      coarse_x,
  input  logic [Y_W-1:0]      py,
  input  logic [1:0]          map_sel,
  input  logic                bank_sel,
  input  logic [TILE_W-1:0]   tile,
  input  logic [1:0]          sub_pal,
  input  logic [1:0]          color_idx,
  output logic [ADDR_W-1:0]   addr
);

  localparam int CX_W = X_W - 3;
  localparam int CY_W = Y_W - 3;

  logic [ADDR_W-1:0] map_base;
  logic [ADDR_W-1:0] row_base;

  assign map_base = ADDR_W'(MAP_BASE) + (ADDR_W'(map_sel) << MAP_STRIDE);
  assign row_base = (ADDR_W'(bank_sel) << BANK_SHIFT) + (ADDR_W'(tile) << TILE_SHIFT)
                  + ADDR_W'(py[2:0]);

  always_comb begin
    case (stage)
      ST_NT:   addr = map_base + (ADDR_W'(py[Y_W-1:3]) << CX_W) + ADDR_W'(coarse_x);
      ST_LO:   addr = row_base;
      ST_HI:   addr = row_base + ADDR_W'(PLANE_GAP);
      ST_AT:   addr = map_base + ADDR_W'(ATTR_OFFSET)
                    + (ADDR_W'(py[Y_W-1:5]) << (CX_W - 2)) + ADDR_W'(coarse_x[CX_W-1:2]);
      ST_PAL:  addr = ADDR_W'(PAL_BASE) + ADDR_W'({sub_pal, color_idx});
      default: addr = '0;
    endcase
  end

  // CY_W is kept for symmetry with CX_W in derived widths
  logic unused_cy;
  assign unused_cy = (CY_W > 0);

endmodule

// File: rtl/bg_tile_decode.sv
module bg_tile_decode #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        fine_x,
  input  logic              quad_x,
  input  logic              quad_y,
  input  logic [DATA_W-1:0] plane_lo,
  input  logic [DATA_W-1:0] plane_hi,
  input  logic [DATA_W-1:0] attr,
  output logic [1:0]        color_idx,
  output logic [1:0]        sub_pal
);

  logic [2:0] bit_pos;
  logic [1:0] quad;

  // leftmost pixel of a row sits in the MSB
  assign bit_pos   = ~fine_x;
  assign color_idx = {plane_hi[bit_pos], plane_lo[bit_pos]};

  assign quad = {quad_y, quad_x};

  always_comb begin
    case (quad)
      2'd0:    sub_pal = attr[1:0];
      2'd1:    sub_pal = attr[3:2];
      2'd2:    sub_pal = attr[5:4];
      default: sub_pal = attr[7:6];
    endcase
  end

endmodule

// File: rtl/bg_pixel_resolver.sv
module bg_pixel_resolver
  import bg_resolve_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 8,
  parameter int X_W     = 8,
  parameter int Y_W     = 8,
  parameter int COLOR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [X_W-1:0]     req_x,
  input  logic [Y_W-1:0]     req_y,
  input  logic [1:0]         req_nt,
  input  logic               req_bank,
  output logic               busy,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]  mem_rd_data,
  output logic               out_valid,
  output logic [COLOR_W-1:0] out_color
);

  stage_t             state_q, next_stage;
  logic               wait_q;
  logic [X_W-1:0]     x_q, cur_x;
  logic [Y_W-1:0]     y_q, cur_y;
  logic [1:0]         nt_q, cur_nt;
  logic               bank_q, cur_bank;
  logic [DATA_W-1:0]  tile_q, tile_in;
  logic [DATA_W-1:0]  lo_q, hi_q;
  logic [1:0]         color_idx, sub_pal;
  logic [ADDR_W-1:0]  fetch_addr;

  always_comb begin
    case (state_q)
      ST_IDLE: next_stage = ST_NT;
      ST_NT:   next_stage = ST_LO;
      ST_LO:   next_stage = ST_HI;
      ST_HI:   next_stage = ST_AT;
      ST_AT:   next_stage = ST_PAL;
      default: next_stage = ST_IDLE;
    endcase
  end

  // while idle the request itself feeds the first address
  assign cur_x    = (state_q == ST_IDLE) ? req_x    : x_q;
  assign cur_y    = (state_q == ST_IDLE) ? req_y    : y_q;
  assign cur_nt   = (state_q == ST_IDLE) ? req_nt   : nt_q;
  assign cur_bank = (state_q == ST_IDLE) ? req_bank : bank_q;
  // tile number and attribute byte are forwarded straight from the read port
  assign tile_in  = (state_q == ST_NT) ? mem_rd_data : tile_q;

  bg_tile_decode #(.DATA_W(DATA_W)) u_decode (
    .fine_x    (x_q[2:0]),
    .quad_x    (x_q[4]),
    .quad_y    (y_q[4]),
    .plane_lo  (lo_q),
    .plane_hi  (hi_q),
    .attr      (mem_rd_data),
    .color_idx (color_idx),
    .sub_pal   (sub_pal)
  );

  bg_fetch_addr #(
    .ADDR_W (ADDR_W),
    .X_W    (X_W),
    .Y_W    (Y_W),
    .TILE_W (DATA_W)
  ) u_addr (
    .stage     (next_stage),
    .coarse_x  (cur_x[X_W-1:3]),
    .py        (cur_y),
    .map_sel   (cur_nt),
    .bank_sel  (cur_bank),
    .tile      (tile_in),
    .sub_pal   (sub_pal),
    .color_idx (color_idx),
    .addr      (fetch_addr)
  );

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wait_q    <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      out_valid <= 1'b0;
      out_color <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      out_valid <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (req_valid) begin
          x_q       <= req_x;
          y_q       <= req_y;
          nt_q      <= req_nt;
          bank_q    <= req_bank;
          state_q   <= next_stage;
          wait_q    <= 1'b0;
          mem_addr  <= fetch_addr;
          mem_rd_en <= 1'b1;
        end
      end else if (!wait_q) begin
        wait_q <= 1'b1;
      end else begin
        wait_q <= 1'b0;
        case (state_q)
          ST_NT:   tile_q <= mem_rd_data;
          ST_LO:   lo_q   <= mem_rd_data;
          ST_HI:   hi_q   <= mem_rd_data;
          default: ;
        endcase
        if (state_q == ST_PAL) begin
          out_valid <= 1'b1;
          out_color <= mem_rd_data[COLOR_W-1:0];
          state_q   <= ST_IDLE;
        end else begin
          state_q   <= next_stage;
          mem_addr  <= fetch_addr;
          mem_rd_en <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bg_pixel_resolver_chk.sv
module bg_pixel_resolver_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              out_valid
);

  // R8
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R8
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8
  valid_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !busy && !mem_rd_en);

  // R9
  idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy && mem_rd_en);

  // R8
  no_read_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd_en);

  // R2
  first_read_map_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mem_addr[ADDR_W-1:ADDR_W-2] == 2'b10);

  // R7
  last_read_palette_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> mem_addr[ADDR_W-1:8] == 6'h3F);

endmodule

bind bg_pixel_resolver bg_pixel_resolver_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .mem_rd_en (mem_rd_en),
  .mem_addr  (mem_addr),
  .out_valid (out_valid)
);

// File: tb/bg_pixel_resolver_tb.sv
module bg_pixel_resolver_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_x = '0;
  logic [7:0]  req_y = '0;
  logic [1:0]  req_nt = '0;
  logic        req_bank = 1'b0;
  logic        busy, mem_rd_en, out_valid;
  logic [13:0] mem_addr;
  logic [7:0]  mem_rd_data = '0;
  logic [5:0]  out_color;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bg_pixel_resolver u_dut (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_x       (req_x),
    .req_y       (req_y),
    .req_nt      (req_nt),
    .req_bank    (req_bank),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rd_data (mem_rd_data),
    .out_valid   (out_valid),
    .out_color   (out_color)
  );

  function automatic int memf(int a);
    int h;
    h = (a * 29) ^ (a >> 3) ^ 'h6C ^ ((a >> 9) * 7);
    return h & 'hFF;
  endfunction

  // video memory with one cycle of read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rd_data <= 8'(memf(int'(mem_addr)));
  end

  // reference model
  int    remain = 0;
  bit    exp_busy = 0, exp_rd = 0, exp_ov = 0;
  int    exp_col = 0;
  int    exp_addr[$];
  string exp_tag[$];
  string cur_tag = "R2";
  string ctl_tag = "R8";

  always @(negedge clk) begin
    checks++;
    if (busy !== exp_busy || mem_rd_en !== exp_rd || out_valid !== exp_ov) begin
      errors++;
      $display("FAIL %s: busy/rd/valid actual %b%b%b expected %b%b%b at cycle %0d",
               ctl_tag, busy, mem_rd_en, out_valid, exp_busy, exp_rd, exp_ov, cyc);
    end
    if (exp_rd && exp_addr.size() > 0) begin
      int a;
      a = exp_addr.pop_front();
      cur_tag = exp_tag.pop_front();
      checks++;
      if (int'(mem_addr) != a) begin
        errors++;
        $display("FAIL %s: mem_addr actual %h expected %h", cur_tag, mem_addr, a);
      end
    end
    if (exp_ov) begin
      checks++;
      if (int'(out_color) != exp_col) begin
        errors++;
        $display("FAIL R5/R6/R7: out_color actual %0d expected %0d", out_color, exp_col);
      end
    end
    // predict the state after the coming edge
    if (rst) begin
      remain = 0; exp_busy = 0; exp_rd = 0; exp_ov = 0;
      ctl_tag = "R1";
      exp_addr.delete(); exp_tag.delete();
    end else begin
      int prev;
      prev = remain;
      ctl_tag = (req_valid && remain > 0) ? "R9" : "R8";
      if (remain == 0 && req_valid) begin
        int x, y, base, tile, lo_a, lo, hi, at_a, attr, ci, q, sub, pal, bp;
        x = int'(req_x); y = int'(req_y);
        base = 'h2000 + int'(req_nt) * 'h400;
        exp_addr.push_back(base + (y / 8) * 32 + x / 8); exp_tag.push_back("R2");
        tile = memf(base + (y / 8) * 32 + x / 8);
        lo_a = int'(req_bank) * 'h1000 + tile * 16 + y % 8;
        exp_addr.push_back(lo_a);     exp_tag.push_back("R3");
        exp_addr.push_back(lo_a + 8); exp_tag.push_back("R3");
        lo = memf(lo_a); hi = memf(lo_a + 8);
        bp = 7 - x % 8;
        ci = ((hi >> bp) & 1) * 2 + ((lo >> bp) & 1);
        at_a = base + 'h3C0 + (y / 32) * 8 + x / 32;
        exp_addr.push_back(at_a); exp_tag.push_back("R4");
        attr = memf(at_a);
        q = ((y % 32) / 16) * 2 + (x % 32) / 16;
        sub = (attr >> (2 * q)) & 3;
        pal = 'h3F00 + sub * 4 + ci;
        exp_addr.push_back(pal); exp_tag.push_back("R7");
        exp_col = memf(pal) & 63;
        remain = 10;
      end else if (remain > 0) begin
        remain--;
      end
      exp_ov   = (prev == 1 && remain == 0);
      exp_busy = (remain > 0);
      exp_rd   = (remain == 10 || remain == 8 || remain == 6 || remain == 4 || remain == 2);
    end
  end

  task automatic one_pixel(input int x, input int y, input int nt, input int bank);
    @(posedge clk); #2;
    req_x = 8'(x); req_y = 8'(y); req_nt = 2'(nt); req_bank = bank[0];
    req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    repeat (10) @(posedge clk);
  endtask

  int lcg = 12345;
  function automatic int nextr();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 'h7FFFFF;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    // R1: reset state checked on every cycle while reset is high
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    repeat (2) @(posedge clk);

    // R2 R3 R4 R5 R6: boundaries of tiles and attribute quadrants
    for (int nt = 0; nt < 4; nt++) begin
      for (int b = 0; b < 2; b++) begin
        one_pixel(0, 0, nt, b);
        one_pixel(255, 239, nt, b);
        one_pixel(15, 15, nt, b);
        one_pixel(16, 0, nt, b);
        one_pixel(0, 16, nt, b);
        one_pixel(31, 31, nt, b);
        one_pixel(32, 32, nt, b);
        one_pixel(7, 8, nt, b);
        one_pixel(8, 7, nt, b);
      end
    end
    // R5: every bit position within one tile row
    for (int fx = 0; fx < 8; fx++) one_pixel(40 + fx, 100, 1, 0);

    // pseudo-random pixels
    for (int i = 0; i < 300; i++) begin
      int r;
      r = nextr();
      one_pixel(r & 255, (r >> 8) % 240, (r >> 16) & 3, (r >> 18) & 1);
    end

    // R9: request held high with coordinates changing every cycle
    @(posedge clk); #2;
    req_valid = 1'b1;
    for (int i = 0; i < 600; i++) begin
      int r;
      r = nextr();
      req_x = 8'(r & 255); req_y = 8'((r >> 8) % 240);
      req_nt = 2'((r >> 16) & 3); req_bank = r[18];
      @(posedge clk); #2;
    end
    req_valid = 1'b0;
    repeat (14) @(posedge clk);

    // R1: reset in the middle of a pixel returns to idle
    one_pixel(100, 100, 2, 1);
    @(posedge clk); #2;
    req_valid = 1'b1; req_x = 8'd60; req_y = 8'd70;
    repeat (4) @(posedge clk);
    #2 rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    repeat (3) @(posedge clk);
    one_pixel(200, 200, 3, 0);
    repeat (3) @(posedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule